// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time-of-Day Counter

This block keeps the time of day for a precision-time hardware clock as a 64-bit count of nanoseconds. Below the nanosecond count sits a 32-bit fraction, and on every enabled clock tick the block adds a programmable 64-bit fixed-point increment to the combined value. The increment has 32 integer bits and 32 fractional bits. A tick period that is not a whole number of nanoseconds therefore accumulates without drift. The count is 64 bits wide, so it needs no separate cycle counter and no overflow handling.

Software reaches the block through a 32-bit register port. The port holds a control word with an enable bit, the time as two halves, and the increment as two halves. Multi-word access is atomic:
- Reading the low time half freezes a copy of the high half for a later read.
- Writing a low half only stages it.
- Writing the high half commits the full 64-bit value.

A link-speed code, together with an apply strobe, loads the default increment for that speed. The running time is also driven straight out on a port, for use by timestamp capture logic.

Top module: `tod_ns_counter`

## Requirements
- R1: On each clock edge with enable set and no time commit, the 96-bit value {time, fraction} grows by the 64-bit increment, with the binary point 32 bits up. Example at 0x0199999999: 5 ticks from a fresh load add 7 ns and 10 ticks add 15 ns.
- R2: A read of address 1 returns time bits 31:0 and captures time bits 63:32 at the same edge. A later read of address 2 returns that captured word, even if the live time has since carried into its upper half.
- R3: A write to address 1 only stages the low time word, and the live time does not change. A write to address 2 loads time = {written word, staged low word} and clears the fraction.
- R4: In the cycle of a time commit, the loaded value wins over the increment, even with enable set. A read issued on the very next edge returns the loaded time exactly.
- R5: A write to address 3 only stages the low increment word. A write to address 4 makes {written word, staged word} the active increment. Reads of addresses 3 and 4 return the active increment halves.
- R6: Address 0 bit 0 is the enable. While it is clear, time and fraction hold, and register writes still take effect.
- R7: An apply strobe loads the default increment for link_speed:
  - code 3 (10 Gb/s) loads 0x0333333333;
  - code 2 (1 Gb/s) loads 0x2000000000;
  - code 0 (no link), code 4 (40 Gb/s) and codes 5 to 7 load 0x0199999999.
- R8: An apply strobe with code 1 (100 Mb/s) sets the increment to zero, so time stops even with enable set.
- R9: After reset, time, fraction and both staged words are zero, the enable is clear and the increment is 0x0199999999.
- R10: Read data is registered. rd_valid is high exactly on the cycle after a read strobe. Unmapped addresses 5 to 7 read as zero.
- R11: time_ns always equals the current nanosecond count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| link_speed | input | 3 | Link speed code |
| speed_apply | input | 1 | Load the default increment for link_speed |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
Time is advanced with three increments: the 1.6 ns default, the 32 ns 1 Gb/s value, and a hand-written increment with a small fraction. The expected count is derived from the tick count after each commit. This separates a correct fractional carry from a truncating or drifting one. A load placed just below a 32-bit boundary, followed by enough ticks to carry, shows whether the high half returned is the captured one or the live one. Frozen and zero-increment runs, staged writes without a commit, and each speed code show that nothing moves when it should not and that each code maps to its own increment.

// File: rtl/tod_ns_counter.sv
module tod_ns_counter #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 32,
  parameter int ADDR_W = 3,
  parameter int SPD_W  = 3,
  parameter logic [2*DATA_W-1:0] INC_FAST = 64'h0000_0001_9999_9999,
  parameter logic [2*DATA_W-1:0] INC_10G  = 64'h0000_0003_3333_3333,
  parameter logic [2*DATA_W-1:0] INC_1G   = 64'h0000_0020_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [SPD_W-1:0]  link_speed,
  input  logic              speed_apply,
  output logic [2*DATA_W-1:0] time_ns
);
  localparam int NS_W  = 2 * DATA_W;
  localparam int INC_W = 2 * DATA_W;
  localparam int ACC_W = NS_W + FRAC_W;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TLO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_THI  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ILO  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IHI  = ADDR_W'(4);

  localparam logic [SPD_W-1:0] SPD_100M = SPD_W'(1);
  localparam logic [SPD_W-1:0] SPD_1G   = SPD_W'(2);
  localparam logic [SPD_W-1:0] SPD_10G  = SPD_W'(3);

  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [INC_W-1:0]  inc_q;
  logic [DATA_W-1:0] tlo_pend_q;
  logic [DATA_W-1:0] ilo_pend_q;
  logic [DATA_W-1:0] hi_latch_q;
  logic              en_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  logic [ACC_W-1:0]  acc_sum;
  logic [INC_W-1:0]  spd_inc;
  logic [DATA_W-1:0] rd_mux;

  wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  wire wr_tlo  = reg_wr && (reg_addr == A_TLO);
  wire wr_thi  = reg_wr && (reg_addr == A_THI);
  wire wr_ilo  = reg_wr && (reg_addr == A_ILO);
  wire wr_ihi  = reg_wr && (reg_addr == A_IHI);
  wire rd_tlo  = reg_rd && (reg_addr == A_TLO);

  assign acc_sum = {ns_q, frac_q} + {{(ACC_W-INC_W){1'b0}}, inc_q};

  always_comb begin
    case (link_speed)
      SPD_100M: spd_inc = '0;
      SPD_1G:   spd_inc = INC_1G;
      SPD_10G:  spd_inc = INC_10G;
      default:  spd_inc = INC_FAST;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_mux = {{(DATA_W-1){1'b0}}, en_q};
      A_TLO:   rd_mux = ns_q[DATA_W-1:0];
      A_THI:   rd_mux = hi_latch_q;
      A_ILO:   rd_mux = inc_q[DATA_W-1:0];
      A_IHI:   rd_mux = inc_q[INC_W-1:DATA_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q       <= '0;
      frac_q     <= '0;
      inc_q      <= INC_FAST;
      tlo_pend_q <= '0;
      ilo_pend_q <= '0;
      hi_latch_q <= '0;
      en_q       <= 1'b0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata[0];
      if (wr_tlo)  tlo_pend_q <= reg_wdata;
      if (wr_ilo)  ilo_pend_q <= reg_wdata;

      if (wr_ihi)           inc_q <= {reg_wdata, ilo_pend_q};
      else if (speed_apply) inc_q <= spd_inc;

      if (wr_thi) begin
        ns_q   <= {reg_wdata, tlo_pend_q};
        frac_q <= '0;
      end else if (en_q) begin
        {ns_q, frac_q} <= acc_sum;
      end

      if (rd_tlo) hi_latch_q <= ns_q[NS_W-1:DATA_W];

      rd_valid_q <= reg_rd;
      if (reg_rd) rd_data_q <= rd_mux;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign time_ns  = ns_q;
endmodule

// File: rtl/tod_ns_counter_chk.sv
module tod_ns_counter_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int SPD_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic                rd_valid,
  input logic [SPD_W-1:0]    link_speed,
  input logic                speed_apply,
  input logic [2*DATA_W-1:0] time_ns,
  input logic                en_q,
  input logic [2*DATA_W-1:0] inc_q
);
  wire commit_hi = reg_wr && (reg_addr == ADDR_W'(2));
  wire inc_hi_wr = reg_wr && (reg_addr == ADDR_W'(4));

  AST_LOAD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hi |=> time_ns[2*DATA_W-1:DATA_W] == $past(reg_wdata)); // R3
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !commit_hi) |=> $stable(time_ns)); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !commit_hi) |=> (time_ns - $past(time_ns)) <= ({{DATA_W{1'b0}}, $past(inc_q[2*DATA_W-1:DATA_W])} + 1)); // R1
  AST_RD_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid); // R10
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rd_valid); // R10
  AST_SLOW_LINK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_apply && link_speed == SPD_W'(1) && !inc_hi_wr) |=> inc_q == '0); // R8
endmodule

bind tod_ns_counter tod_ns_counter_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SPD_W(SPD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rd_valid(rd_valid), .link_speed(link_speed),
  .speed_apply(speed_apply), .time_ns(time_ns), .en_q(en_q), .inc_q(inc_q)
);

// File: tb/tod_ns_counter_tb_top.sv
`timescale 1ns/1ps
module tod_ns_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [2:0]  link_speed = '0;
  logic        speed_apply = 1'b0;
  logic [63:0] time_ns;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  tod_ns_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .link_speed(link_speed), .speed_apply(speed_apply), .time_ns(time_ns)
  );

  function automatic logic [63:0] ns_after(logic [63:0] t, logic [63:0] inc, int k);
    logic [95:0] a;
    a = {t, 32'h0} + {32'h0, inc} * 96'(k);
    return a[95:32];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic apply_speed(logic [2:0] code);
    link_speed = code; speed_apply = 1'b1;
    @(negedge clk);
    speed_apply = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: actual rd_valid=1 expected 0 with no read pending");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {32'h0, rd_data}, {32'h0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] t;
    logic [63:0] inc;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R9 time zero", time_ns, 64'h0);
    rd(3'd3, 32'h9999_9999, "R9 inc lo");
    rd(3'd4, 32'h0000_0001, "R9 inc hi");
    rd(3'd0, 32'h0, "R9 enable clear");

    wr(3'd2, 32'h5);
    check("R9 staged low zero", time_ns, 64'h5_0000_0000);
    rd(3'd1, 32'h0, "R2 lo");
    rd(3'd2, 32'h5, "R2 hi");

    wr(3'd1, 32'h1234);
    idle(3);
    check("R3 staged low no effect", time_ns, 64'h5_0000_0000);
    wr(3'd2, 32'hA);
    check("R3 commit", time_ns, 64'hA_0000_1234);
    idle(20);
    check("R6 frozen", time_ns, 64'hA_0000_1234);

    wr(3'd0, 32'h1);
    rd(3'd0, 32'h1, "R6 enable readback");
    t = 64'h2_FFFF_FFF8;
    inc = 64'h1_9999_9999;
    wr(3'd1, t[31:0]);
    wr(3'd2, t[63:32]);
    rd(3'd1, t[31:0], "R4 commit beats increment");
    wr(3'd1, t[31:0]);
    wr(3'd2, t[63:32]);
    idle(10);
    rd(3'd1, ns_after(t, inc, 10) >> 0 & 64'hFFFF_FFFF, "R1 1.6ns x10");
    rd(3'd2, 32'(ns_after(t, inc, 10) >> 32), "R1 1.6ns x10 hi");
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    idle(5);
    rd(3'd1, 32'd7, "R1 1.6ns x5");

    apply_speed(3'd2);
    rd(3'd3, 32'h0, "R7 1G lo");
    rd(3'd4, 32'h20, "R7 1G hi");
    inc = 64'h20_0000_0000;
    t = 64'h0000_0000_FFFF_FF00;
    wr(3'd1, t[31:0]);
    wr(3'd2, t[63:32]);
    rd(3'd1, t[31:0], "R2 lo before carry");
    idle(20);
    rd(3'd2, 32'h0, "R2 captured hi held");
    rd(3'd1, 32'(ns_after(t, inc, 22)), "R2 lo after carry");
    rd(3'd2, 32'(ns_after(t, inc, 22) >> 32), "R2 hi after carry");
    check("R11 time port after carry", time_ns, ns_after(t, inc, 24));

    wr(3'd3, 32'h5);
    rd(3'd3, 32'h0, "R5 staged inc lo no effect");
    wr(3'd4, 32'h4);
    rd(3'd3, 32'h5, "R5 inc lo");
    rd(3'd4, 32'h4, "R5 inc hi");
    inc = 64'h4_0000_0005;
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    idle(7);
    rd(3'd1, 32'(ns_after(64'h0, inc, 7)), "R5 new rate");

    apply_speed(3'd3);
    rd(3'd3, 32'h3333_3333, "R7 10G lo");
    rd(3'd4, 32'h3, "R7 10G hi");
    apply_speed(3'd0);
    rd(3'd3, 32'h9999_9999, "R7 no link lo");
    rd(3'd4, 32'h1, "R7 no link hi");
    apply_speed(3'd1);
    rd(3'd4, 32'h0, "R8 100M hi");
    apply_speed(3'd4);
    rd(3'd4, 32'h1, "R7 40G hi");
    apply_speed(3'd7);
    rd(3'd3, 32'h9999_9999, "R7 code7 lo");

    apply_speed(3'd1);
    wr(3'd1, 32'h77);
    wr(3'd2, 32'h0);
    idle(10);
    check("R8 clock stopped", time_ns, 64'h77);
    rd(3'd1, 32'h77, "R8 read stopped");

    rd(3'd6, 32'h0, "R10 unmapped");
    idle(3);
    check("R10 queue drained", 64'(exp_q.size()), 64'h0);
    check("R10 rd_valid idle", {63'h0, rd_valid}, 64'h0);
    finish_run();
  end
endmodule